// File: doc/BRIEF.md
# Programmed I/O Controller

This block sits beside a processor's register file and executes the words that move data to and from peripheral devices. It takes one instruction word per accepted transfer together with the current A and B register values. It drives a single shared device bus that carries a device code, a register index, read and write strobes and a one-cycle pulse. One cycle later it returns a result: an optional write-back to A or B and a skip indication for the sequencer.

For each of 64 device codes the block keeps a BUSY flag and a DONE flag. Instructions start and stop devices through these flags, and a device reports that it has finished by pulsing its completion line. A device whose DONE flag is set and whose mask bit is set raises the shared interrupt request. An acknowledge word returns the lowest requesting device code in B, and an I/O reset word returns every device to idle.

The instruction input uses a valid/ready handshake. Ready is low during reset and high at all times after it, so the block never applies back-pressure. A word is accepted in any cycle where valid and ready are both high. Every accepted word produces exactly one `res_valid_o` pulse one cycle later. The result side has no ready, and its consumer must take each pulse as it arrives.

Top module: `pio_ctrl`

## Requirements
- R1: An I/O word (bits 17..13 = 00001) with mode field (bits 9..7) 1, 2 or 3 asserts `dev_rd_o` with `dev_reg_o` equal to the mode. One cycle later it writes the returned data back with `res_we_o`, to A when bit 12 is 1 and to B when bit 12 is 0.
- R2: An I/O word with mode 4, 5 or 6 asserts `dev_wr_o` in the acceptance cycle, with `dev_reg_o` equal to mode minus 3 and `dev_wdata_o` taken from A (bit 12 = 1) or B (bit 12 = 0). No write-back follows.
- R3: In modes 1 to 6 the function field (bits 11..10) acts on the addressed device's flags. Function 1 sets BUSY and clears DONE. Function 2 clears both flags.
- R4: Function 3 in modes 1 to 6 drives `dev_pulse_o` high for the acceptance cycle only. Function 0 leaves both flags unchanged.
- R5: Mode 7 asserts `res_skip_o` one cycle later when the condition holds: 0 means BUSY, 1 means not BUSY, 2 means DONE and 3 means not DONE. Mode 7 writes no register and changes no flag.
- R6: A pulse on `dev_fin_i[d]` clears BUSY and sets DONE of device d. If an instruction changes the same device's flags in the same cycle, the instruction wins.
- R7: `irq_o` is high exactly while some device has DONE set together with its `irq_mask_i` bit.
- R8: Word 000003 (octal) writes B, one cycle later, with the lowest device code whose DONE and mask bits are both set, or with 0 when no such device exists.
- R9: Word 000017 (octal) clears BUSY and DONE of every device.
- R10: A read from a register that no device answers (`dev_rack_i` low) writes back 0.
- R11: After reset `ins_ready_o` is high, `res_valid_o` is low and all flags are clear. A word that is neither an I/O word nor 000003 nor 000017 gives a result pulse with no write-back and no skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ins_valid_i | input | 1 | Instruction word valid |
| ins_ready_o | output | 1 | Instruction word can be accepted |
| ins_word_i | input | 17 | Instruction word |
| a_i | input | 17 | Current A register |
| b_i | input | 17 | Current B register |
| res_valid_o | output | 1 | One pulse per accepted word |
| res_we_o | output | 1 | Write `res_data_o` to a CPU register |
| res_to_a_o | output | 1 | Write-back target: 1 = A, 0 = B |
| res_data_o | output | 17 | Write-back data |
| res_skip_o | output | 1 | Skip the next instruction |
| dev_code_o | output | 6 | Addressed device code |
| dev_reg_o | output | 2 | Device register index 1..3 |
| dev_rd_o | output | 1 | Device register read strobe |
| dev_wr_o | output | 1 | Device register write strobe |
| dev_wdata_o | output | 17 | Device write data |
| dev_pulse_o | output | 1 | One-cycle device pulse |
| dev_rdata_i | input | 17 | Device read data, same cycle as `dev_rd_o` |
| dev_rack_i | input | 1 | A device answered the read |
| dev_fin_i | input | 64 | Per-device completion pulse |
| irq_mask_i | input | 64 | Per-device interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The checker assumes that the acknowledge and reset words take effect only when they are accepted. It also assumes that read data and the answer line are valid in the same cycle as the read strobe. The bench keeps to this by means of a combinational device model at codes 5, 12 and 40. That model answers only its own code and only while the read strobe is high. Completion pulses and mask changes are applied only at falling edges, so they never fall between the acceptance edge and the sample taken one cycle later. Random words mix I/O words aimed at present and absent devices with acknowledge, reset and unrelated words.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int WORD_W = 17;
  localparam int CODE_W = 6;

  typedef enum logic [1:0] {
    FN_NONE  = 2'd0,
    FN_START = 2'd1,
    FN_STOP  = 2'd2,
    FN_PULSE = 2'd3
  } fn_e;

  typedef struct packed {
    logic              is_io;
    logic              sel_a;
    fn_e               fn;
    logic [2:0]        mode;
    logic [CODE_W-1:0] code;
    logic              rd;
    logic              wr;
    logic              test;
    logic [1:0]        reg_idx;
    logic              is_ack;
    logic              is_iorst;
  } dec_t;
endpackage

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output dec_t              dec_o
);
  logic       io;
  logic [2:0] md;

  always_comb begin
    io = (word_i[16:12] == 5'b00001);
    md = word_i[8:6];
    dec_o.is_io    = io;
    dec_o.sel_a    = word_i[11];
    dec_o.fn       = fn_e'(word_i[10:9]);
    dec_o.mode     = md;
    dec_o.code     = word_i[CODE_W-1:0];
    dec_o.rd       = io && (md >= 3'd1) && (md <= 3'd3);
    dec_o.wr       = io && (md >= 3'd4) && (md <= 3'd6);
    dec_o.test     = io && (md == 3'd7);
    dec_o.reg_idx  = 2'd0;
    if (dec_o.rd) dec_o.reg_idx = md[1:0];
    else if (dec_o.wr) dec_o.reg_idx = 2'(md - 3'd3);
    dec_o.is_ack   = (word_i == WORD_W'(3));
    dec_o.is_iorst = (word_i == WORD_W'(15));
  end
endmodule

// File: rtl/pio_flags.sv
module pio_flags
  import pio_pkg::*;
#(
  parameter int NDEV = 64,
  localparam int IW = $clog2(NDEV)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_all_i,
  input  logic            cmd_v_i,
  input  logic [IW-1:0]   cmd_code_i,
  input  fn_e             cmd_fn_i,
  input  logic [NDEV-1:0] fin_i,
  output logic [NDEV-1:0] busy_o,
  output logic [NDEV-1:0] done_o
);
  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    logic hit;
    assign hit = cmd_v_i && (cmd_code_i == IW'(d));
    always_ff @(posedge clk_i) begin
      if (!rst_ni || clr_all_i) begin
        busy_o[d] <= 1'b0;
        done_o[d] <= 1'b0;
      end else if (hit && cmd_fn_i == FN_START) begin
        busy_o[d] <= 1'b1;
        done_o[d] <= 1'b0;
      end else if (hit && cmd_fn_i == FN_STOP) begin
        busy_o[d] <= 1'b0;
        done_o[d] <= 1'b0;
      end else if (fin_i[d]) begin
        busy_o[d] <= 1'b0;
        done_o[d] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pio_prio.sv
module pio_prio #(
  parameter int N = 64,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int CW = CODE_W,
  localparam int NDEV = 1 << CW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ins_valid_i,
  output logic            ins_ready_o,
  input  logic [DW-1:0]   ins_word_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic            res_valid_o,
  output logic            res_we_o,
  output logic            res_to_a_o,
  output logic [DW-1:0]   res_data_o,
  output logic            res_skip_o,
  output logic [CW-1:0]   dev_code_o,
  output logic [1:0]      dev_reg_o,
  output logic            dev_rd_o,
  output logic            dev_wr_o,
  output logic [DW-1:0]   dev_wdata_o,
  output logic            dev_pulse_o,
  input  logic [DW-1:0]   dev_rdata_i,
  input  logic            dev_rack_i,
  input  logic [NDEV-1:0] dev_fin_i,
  input  logic [NDEV-1:0] irq_mask_i,
  output logic            irq_o
);
  dec_t            dec;
  logic            rdy_q;
  logic            acc;
  logic [NDEV-1:0] busy;
  logic [NDEV-1:0] done;
  logic [NDEV-1:0] pend;
  logic            pend_any;
  logic [CW-1:0]   pend_idx;
  logic            cond;

  pio_decode u_dec (.word_i(ins_word_i), .dec_o(dec));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) rdy_q <= 1'b0;
    else         rdy_q <= 1'b1;
  end
  assign ins_ready_o = rdy_q;
  assign acc         = ins_valid_i && rdy_q;

  pio_flags #(.NDEV(NDEV)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_all_i  (acc && dec.is_iorst),
    .cmd_v_i    (acc && (dec.rd || dec.wr)),
    .cmd_code_i (dec.code),
    .cmd_fn_i   (dec.fn),
    .fin_i      (dev_fin_i),
    .busy_o     (busy),
    .done_o     (done)
  );

  assign pend = done & irq_mask_i;

  pio_prio #(.N(NDEV)) u_prio (.req_i(pend), .any_o(pend_any), .idx_o(pend_idx));
  assign irq_o = pend_any;

  assign dev_code_o  = dec.code;
  assign dev_reg_o   = dec.reg_idx;
  assign dev_rd_o    = acc && dec.rd;
  assign dev_wr_o    = acc && dec.wr;
  assign dev_wdata_o = dec.sel_a ? a_i : b_i;
  assign dev_pulse_o = acc && (dec.rd || dec.wr) && (dec.fn == FN_PULSE);

  always_comb begin
    unique case (dec.fn)
      FN_NONE:  cond = busy[dec.code];
      FN_START: cond = !busy[dec.code];
      FN_STOP:  cond = done[dec.code];
      default:  cond = !done[dec.code];
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_we_o    <= 1'b0;
      res_to_a_o  <= 1'b0;
      res_data_o  <= '0;
      res_skip_o  <= 1'b0;
    end else begin
      res_valid_o <= acc;
      res_we_o    <= acc && (dec.rd || dec.is_ack);
      res_to_a_o  <= dec.rd && dec.sel_a;
      res_skip_o  <= acc && dec.test && cond;
      if (dec.is_ack)       res_data_o <= DW'(pend_idx);
      else if (dev_rack_i)  res_data_o <= dev_rdata_i;
      else                  res_data_o <= '0;
    end
  end
endmodule

// File: rtl/pio_ctrl_chk.sv
module pio_ctrl_chk #(
  parameter int DW = 17,
  parameter int NDEV = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ins_valid_i,
  input logic            ins_ready_o,
  input logic [DW-1:0]   ins_word_i,
  input logic            res_valid_o,
  input logic            res_we_o,
  input logic [DW-1:0]   res_data_o,
  input logic            irq_o,
  input logic [NDEV-1:0] busy,
  input logic [NDEV-1:0] done
);
  logic acc, io16, xfer;
  assign acc  = ins_valid_i && ins_ready_o;
  assign io16 = (ins_word_i[16:12] == 5'b00001);
  assign xfer = io16 && (ins_word_i[8:6] != 3'd0) && (ins_word_i[8:6] != 3'd7);

  p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && xfer && ins_word_i[10:9] == 2'd1)
      |=> (busy[$past(ins_word_i[5:0])] && !done[$past(ins_word_i[5:0])]));

  p_stop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && xfer && ins_word_i[10:9] == 2'd2)
      |=> (!busy[$past(ins_word_i[5:0])] && !done[$past(ins_word_i[5:0])]));

  p_iorst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && ins_word_i == DW'(15)) |=> (busy == '0 && done == '0 && !irq_o));

  p_ack_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && ins_word_i == DW'(3) && !irq_o) |=> (res_we_o && res_data_o == '0));

  p_one_result_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> (res_valid_o == $past(acc)));

  p_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ins_ready_o);
endmodule

bind pio_ctrl pio_ctrl_chk #(.DW(DW), .NDEV(NDEV)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ins_valid_i (ins_valid_i),
  .ins_ready_o (ins_ready_o),
  .ins_word_i  (ins_word_i),
  .res_valid_o (res_valid_o),
  .res_we_o    (res_we_o),
  .res_data_o  (res_data_o),
  .irq_o       (irq_o),
  .busy        (busy),
  .done        (done)
);

// File: tb/pio_ctrl_tb_top.sv
`timescale 1ns/1ps
module pio_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [16:0] ins_word = '0, a_v = '0, b_v = '0;
  logic        res_valid, res_we, res_to_a, res_skip;
  logic [16:0] res_data;
  logic [5:0]  dev_code;
  logic [1:0]  dev_reg;
  logic        dev_rd, dev_wr, dev_pulse;
  logic [16:0] dev_wdata, dev_rdata;
  logic        dev_rack;
  logic [63:0] fin = '0, mask = '0;
  logic        irq;

  always #4 clk = ~clk;

  pio_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ins_valid_i(ins_valid), .ins_ready_o(ins_ready),
    .ins_word_i(ins_word), .a_i(a_v), .b_i(b_v), .res_valid_o(res_valid),
    .res_we_o(res_we), .res_to_a_o(res_to_a), .res_data_o(res_data),
    .res_skip_o(res_skip), .dev_code_o(dev_code), .dev_reg_o(dev_reg),
    .dev_rd_o(dev_rd), .dev_wr_o(dev_wr), .dev_wdata_o(dev_wdata),
    .dev_pulse_o(dev_pulse), .dev_rdata_i(dev_rdata), .dev_rack_i(dev_rack),
    .dev_fin_i(fin), .irq_mask_i(mask), .irq_o(irq)
  );

  int total = 0, bad = 0;

  // device model: three devices with three registers each
  logic [16:0] dregs [3][3];
  logic [16:0] exp_regs [3][3];
  bit busy_m [64];
  bit done_m [64];

  function automatic int slot_of(input logic [5:0] c);
    if (c == 6'd5)  return 0;
    if (c == 6'd12) return 1;
    if (c == 6'd40) return 2;
    return -1;
  endfunction

  always_comb begin
    dev_rack  = 1'b0;
    dev_rdata = '0;
    if (dev_rd && slot_of(dev_code) >= 0 && dev_reg != 2'd0) begin
      dev_rack  = 1'b1;
      dev_rdata = dregs[slot_of(dev_code)][dev_reg - 2'd1];
    end
  end

  always @(posedge clk) begin
    if (dev_wr && slot_of(dev_code) >= 0 && dev_reg != 2'd0)
      dregs[slot_of(dev_code)][dev_reg - 2'd1] <= dev_wdata;
  end

  function automatic logic [16:0] iow(input bit sa, input int fn, input int md, input int code);
    return {5'b00001, sa, 2'(fn), 3'(md), 6'(code)};
  endfunction

  function automatic logic exp_irq();
    for (int d = 0; d < 64; d++) if (done_m[d] && mask[d]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [16:0] exp_ack();
    for (int d = 0; d < 64; d++) if (done_m[d] && mask[d]) return 17'(d);
    return '0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic op(input logic [16:0] w, input logic [16:0] a, input logic [16:0] b,
                    input logic [63:0] f);
    bit io = (w[16:12] == 5'b00001);
    bit sa = w[11];
    int fn = int'(w[10:9]);
    int md = int'(w[8:6]);
    int c  = int'(w[5:0]);
    int s  = slot_of(w[5:0]);
    bit rd = io && md >= 1 && md <= 3;
    bit wr = io && md >= 4 && md <= 6;
    bit e_we = 1'b0, e_toa = 1'b0, e_skip = 1'b0;
    logic [16:0] e_data = '0;
    if (rd) begin
      e_we = 1'b1; e_toa = sa;
      e_data = (s >= 0) ? exp_regs[s][md-1] : 17'd0;
    end
    if (io && md == 7)
      case (fn)
        0: e_skip = busy_m[c];
        1: e_skip = !busy_m[c];
        2: e_skip = done_m[c];
        default: e_skip = !done_m[c];
      endcase
    if (w == 17'd3) begin e_we = 1'b1; e_toa = 1'b0; e_data = exp_ack(); end
    @(negedge clk);
    ins_valid = 1'b1; ins_word = w; a_v = a; b_v = b; fin = f;
    #1;
    chk(dev_rd == rd, "R1 read strobe", 64'(dev_rd), 64'(rd));
    chk(dev_wr == wr, "R2 write strobe", 64'(dev_wr), 64'(wr));
    chk(dev_pulse == ((rd || wr) && fn == 3), "R4 pulse", 64'(dev_pulse), 64'((rd || wr) && fn == 3));
    if (rd) chk(dev_reg == 2'(md), "R1 reg index", 64'(dev_reg), 64'(md));
    if (wr) begin
      chk(dev_reg == 2'(md - 3), "R2 reg index", 64'(dev_reg), 64'(md - 3));
      chk(dev_wdata == (sa ? a : b), "R2 write data", 64'(dev_wdata), 64'(sa ? a : b));
      if (s >= 0) exp_regs[s][md-4] = sa ? a : b;
    end
    @(negedge clk);
    ins_valid = 1'b0; fin = '0;
    chk(res_valid, "R11 result pulse", 64'(res_valid), 64'd1);
    chk(res_we == e_we, "R1 write-back enable", 64'(res_we), 64'(e_we));
    if (e_we) begin
      chk(res_to_a == e_toa, "R1 target", 64'(res_to_a), 64'(e_toa));
      chk(res_data == e_data, (w == 17'd3) ? "R8 ack code" : (s < 0 ? "R10 absent read" : "R1 read data"),
          64'(res_data), 64'(e_data));
    end
    chk(res_skip == e_skip, "R5 skip", 64'(res_skip), 64'(e_skip));
    for (int d = 0; d < 64; d++) begin
      if (w == 17'd15) begin busy_m[d] = 0; done_m[d] = 0; end
      else if ((rd || wr) && c == d && fn == 1) begin busy_m[d] = 1; done_m[d] = 0; end
      else if ((rd || wr) && c == d && fn == 2) begin busy_m[d] = 0; done_m[d] = 0; end
      else if (f[d]) begin busy_m[d] = 0; done_m[d] = 1; end
    end
    chk(irq == exp_irq(), "R7 irq", 64'(irq), 64'(exp_irq()));
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 3; i++) for (int j = 0; j < 3; j++) begin
      dregs[i][j] = '0; exp_regs[i][j] = '0;
    end
    for (int d = 0; d < 64; d++) begin busy_m[d] = 0; done_m[d] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(ins_ready == 1'b1, "R11 ready after reset", 64'(ins_ready), 64'd1);
    chk(res_valid == 1'b0, "R11 no result after reset", 64'(res_valid), 64'd0);
    chk(irq == 1'b0, "R11 irq after reset", 64'(irq), 64'd0);
    mask = '1;
    // R5 idle device: not busy skips on cond 1 only
    op(iow(1, 0, 7, 5), 0, 0, 0);
    op(iow(1, 1, 7, 5), 0, 0, 0);
    // R2 writes from A and B, R1 read back
    op(iow(1, 0, 4, 5), 17'o123456, 17'o1, 0);
    op(iow(0, 0, 5, 5), 17'o7, 17'o377777, 0);
    op(iow(1, 0, 6, 40), 17'o55, 0, 0);
    op(iow(1, 0, 1, 5), 0, 0, 0);
    op(iow(0, 0, 2, 5), 0, 0, 0);
    op(iow(0, 0, 3, 40), 0, 0, 0);
    // R10 absent device
    op(iow(1, 0, 2, 20), 0, 0, 0);
    // R3 start 12, then busy test
    op(iow(1, 1, 4, 12), 17'o11, 0, 0);
    op(iow(1, 0, 7, 12), 0, 0, 0);
    // R6 completion, R7 irq, R8 ack
    op(17'd0, 0, 0, 64'd1 << 12);
    op(iow(1, 2, 7, 12), 0, 0, 0);
    op(17'd3, 0, 0, 64'd1 << 40);
    op(17'd3, 0, 0, 0);
    mask = ~(64'd1 << 12);
    op(17'd3, 0, 0, 0);
    // R6 instruction beats completion on same device
    op(iow(0, 1, 1, 5), 0, 0, 64'd1 << 5);
    // R4 pulse with no flag change, R3 stop
    op(iow(1, 3, 5, 40), 17'o3, 0, 0);
    op(iow(1, 2, 1, 40), 0, 0, 0);
    // R9 reset all, R8 empty ack
    op(17'd15, 0, 0, 0);
    op(iow(1, 3, 7, 40), 0, 0, 0);
    op(17'd3, 0, 0, 0);
    // R11 unrelated word
    op(17'o032002, 0, 0, 0);
    // random mix
    for (int k = 0; k < 600; k++) begin
      int pick = int'($urandom_range(0, 19));
      int cs = int'($urandom_range(0, 5));
      int code = (cs == 0) ? 5 : (cs == 1) ? 12 : (cs == 2) ? 40 : (cs == 3) ? 0 : int'($urandom_range(0, 63));
      logic [16:0] w;
      logic [63:0] f = '0;
      if (pick == 0) w = 17'd3;
      else if (pick == 1 && $urandom_range(0, 3) == 0) w = 17'd15;
      else if (pick == 2) w = 17'($urandom);
      else w = iow(1'($urandom), int'($urandom_range(0, 3)), int'($urandom_range(0, 7)), code);
      if ($urandom_range(0, 2) == 0) f[code] = 1'b1;
      if ($urandom_range(0, 3) == 0) f[int'($urandom_range(0, 63))] = 1'b1;
      if ($urandom_range(0, 15) == 0) mask = {$urandom, $urandom};
      op(w, 17'($urandom), 17'($urandom), f);
    end
    finish_run();
  end
endmodule